// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a small first-level cache that sits between a requester issuing single-word reads and writes and a slower backing store that moves whole four-word lines. It is direct-mapped: every memory line has exactly one slot it may occupy. Each slot keeps a tag, a valid marker and a dirty marker. Hits are answered in the same cycle. Writes stay in the cache and mark the slot dirty, so the backing store is updated only when the slot is evicted.

A request address is first wrapped onto the 1024-word space. It is then cut into a 2-bit word offset, a 5-bit slot index and a 3-bit tag. On a miss the controller answers "wait" and runs one or two line transactions on the memory port. If the slot holds a dirty line, that line is written back first. The requested line is then read in. The tag is installed only when that read completes, and the request turns into a hit on the following cycle. The requester must hold its request steady until it sees "done". Only one request is in flight at a time.

Top module: `wbdm_cache`

## Requirements
- R1: The request address is a 16-bit two's complement value. It is reduced modulo 1024, so -10 selects word 1014 and 1049 selects word 25.
- R2: In the wrapped address, bits [1:0] select the word in the line, bits [6:2] select the slot and bits [9:7] form the tag. Address 0b0100111011 therefore has tag 0b010, slot 0b01110 and word 0b11.
- R3: A read that hits gives rsp_code 2 (done) in the same cycle it is presented, with the addressed word on rsp_rdata, and starts no memory transaction.
- R4: A write that hits gives done in the same cycle, stores the word in the cache, marks the slot dirty and starts no memory transaction. A later read of that word returns the new value.
- R5: After reset every slot is invalid and clean, so the first access to any address misses without a writeback. With no request and no miss in progress, rsp_code is 0 and mem_req is 0.
- R6: A miss on a clean or invalid slot performs exactly one line read at word address {tag, slot, 00}. With the 3-cycle memory, the request sees exactly 5 wait cycles and then done.
- R7: A miss on a dirty slot first writes that slot's line (word k in mem_wdata bits [32k+31:32k]) to {old tag, slot, 00}. It then reads the new line. The request sees exactly 9 wait cycles and then done.
- R8: While a line transaction is open, including its acknowledge cycle, rsp_code is 1 (wait) and never done.
- R9: mem_req stays high with stable mem_addr and mem_write until mem_ack. A writeback acknowledge is followed at once by the refill read.
- R10: A completed writeback leaves the refilled slot clean. Evicting it again without any write causes no further writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until done |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_addr | input | 16 | Two's complement word address, wrapped to 10 bits |
| req_wdata | input | 32 | Write data |
| rsp_code | output | 2 | 0 none, 1 wait, 2 done |
| rsp_rdata | output | 32 | Read data, valid with done |
| mem_req | output | 1 | Line transaction open |
| mem_write | output | 1 | 1 = line writeback, 0 = line read |
| mem_addr | output | 10 | Word address of the line base |
| mem_wdata | output | 128 | Line being written back, word k at bits [32k+31:32k] |
| mem_ack | input | 1 | One-cycle completion of the open transaction |
| mem_rdata | input | 128 | Line read data, valid with mem_ack |

## Verification
A wrong tag, valid bit or dirty bit shows at the ports as the wrong number of wait cycles: a hit becomes a 5- or 9-cycle miss, or a miss becomes a hit. It can also show as a missing or extra writeback, visible on the memory port within one cycle of the request. Wrong line data shows as a read value differing from the requester's own view of memory. This can stay hidden until a later read of the word, or until the line is written back and read in again. The bench therefore keeps a small address pool, so that slots are evicted and refilled many times.

// File: rtl/wbdm_pkg.sv
// Package: response codes and miss-sequencer states shared by the cache.
package wbdm_pkg;
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_WAIT = 2'd1,
        RSP_DONE = 2'd2
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2
    } miss_st_e;
endpackage

// File: rtl/wbdm_addr_split.sv
// Wraps a two's complement request address onto the memory word space and
// cuts it into tag, slot index and word offset.
// Assumes the memory size is a power of two, so wrapping is a bit select.
module wbdm_addr_split #(
    parameter int REQ_W  = 16,
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 5,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [REQ_W-1:0] raw_addr,
    output logic [TAG_W-1:0] f_tag,
    output logic [IDX_W-1:0] f_idx,
    output logic [OFF_W-1:0] f_off
);
    logic [ADDR_W-1:0] wrapped;

    // Modulo 2^ADDR_W of a two's complement value is its low bits.
    always_comb begin
        wrapped = raw_addr[ADDR_W-1:0];
        f_off   = wrapped[OFF_W-1:0];
        f_idx   = wrapped[OFF_W +: IDX_W];
        f_tag   = wrapped[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/wbdm_meta_store.sv
// Per-slot tag, valid and dirty storage with one shared slot select.
// Assumes at most one of fill/clear/set is active in a cycle (fill wins).
module wbdm_meta_store #(
    parameter int IDX_W = 5,
    parameter int TAG_W = 3,
    localparam int SLOTS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             clr_dirty,
    input  logic             set_dirty,
    output logic [TAG_W-1:0] cur_tag,
    output logic             cur_valid,
    output logic             cur_dirty
);
    logic [TAG_W-1:0] tag_q   [SLOTS];
    logic [SLOTS-1:0] valid_q;
    logic [SLOTS-1:0] dirty_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Update one slot's metadata when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g]   <= '0;
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (sel_idx == IDX_W'(g)) begin
                if (fill_en) begin
                    tag_q[g]   <= fill_tag;
                    valid_q[g] <= 1'b1;
                    dirty_q[g] <= 1'b0;
                end else if (clr_dirty) begin
                    dirty_q[g] <= 1'b0;
                end else if (set_dirty) begin
                    dirty_q[g] <= 1'b1;
                end
            end
        end
    end

    // Read port for the selected slot.
    always_comb begin
        cur_tag   = tag_q[sel_idx];
        cur_valid = valid_q[sel_idx];
        cur_dirty = dirty_q[sel_idx];
    end
endmodule

// File: rtl/wbdm_data_store.sv
// Cache data array: word write for hits, whole-line write for refills,
// combinational word and line read of the selected slot.
// Assumes word and line writes never occur in the same cycle.
module wbdm_data_store #(
    parameter int IDX_W  = 5,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32,
    localparam int SLOTS = 1 << IDX_W,
    localparam int WORDS = 1 << OFF_W,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [OFF_W-1:0]  sel_off,
    input  logic              word_we,
    input  logic [DATA_W-1:0] word_wdata,
    input  logic              line_we,
    input  logic [LINE_W-1:0] line_wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic [LINE_W-1:0] rd_line
);
    logic [DATA_W-1:0] arr_q [SLOTS][WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Write one word column from a hit or from a refill.
        always_ff @(posedge clk) begin
            if (line_we) begin
                arr_q[sel_idx][w] <= line_wdata[w*DATA_W +: DATA_W];
            end else if (word_we && sel_off == OFF_W'(w)) begin
                arr_q[sel_idx][w] <= word_wdata;
            end
        end
        // Pack the selected line, word w at bits [w*DATA_W +: DATA_W].
        assign rd_line[w*DATA_W +: DATA_W] = arr_q[sel_idx][w];
    end

    // Word read for the requester.
    assign rd_word = arr_q[sel_idx][sel_off];
endmodule

// File: rtl/wbdm_miss_fsm.sv
// Miss sequencer: idle, optional writeback of a dirty victim, then refill.
// Assumes the requester holds its request until done and mem_ack is a pulse.
module wbdm_miss_fsm
    import wbdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic hit,
    input  logic victim_dirty,
    input  logic mem_ack,
    output logic busy,
    output logic mem_req,
    output logic mem_write,
    output logic fill_en,
    output logic clr_dirty
);
    miss_st_e st_q, st_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and memory-side controls.
    always_comb begin
        st_d      = st_q;
        mem_req   = 1'b0;
        mem_write = 1'b0;
        fill_en   = 1'b0;
        clr_dirty = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid && !hit) st_d = victim_dirty ? ST_WB : ST_FILL;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_write = 1'b1;
                if (mem_ack) begin
                    clr_dirty = 1'b1;
                    st_d      = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/wbdm_cache.sv
// Direct-mapped write-back cache controller top.
// Hits answer combinationally; misses run writeback (if dirty) then refill.
// Assumes one request at a time, held stable until rsp_code is done.
module wbdm_cache
    import wbdm_pkg::*;
#(
    parameter int REQ_W  = 16,
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = (1 << OFF_W) * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic [TAG_W-1:0] a_tag, cur_tag;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    logic cur_valid, cur_dirty, hit, busy, fill_en, clr_dirty, wr_hit;

    wbdm_addr_split #(.REQ_W(REQ_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
        .raw_addr(req_addr), .f_tag(a_tag), .f_idx(a_idx), .f_off(a_off)
    );

    wbdm_meta_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_meta (
        .clk(clk), .rst_n(rst_n), .sel_idx(a_idx),
        .fill_en(fill_en), .fill_tag(a_tag),
        .clr_dirty(clr_dirty), .set_dirty(wr_hit),
        .cur_tag(cur_tag), .cur_valid(cur_valid), .cur_dirty(cur_dirty)
    );

    wbdm_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .sel_idx(a_idx), .sel_off(a_off),
        .word_we(wr_hit), .word_wdata(req_wdata),
        .line_we(fill_en), .line_wdata(mem_rdata),
        .rd_word(rsp_rdata), .rd_line(mem_wdata)
    );

    wbdm_miss_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit),
        .victim_dirty(cur_dirty), .mem_ack(mem_ack), .busy(busy),
        .mem_req(mem_req), .mem_write(mem_write),
        .fill_en(fill_en), .clr_dirty(clr_dirty)
    );

    // Hit detection and write-hit enable; only in idle.
    always_comb begin
        hit    = cur_valid && (cur_tag == a_tag);
        wr_hit = req_valid && req_write && hit && !busy;
    end

    // Response code toward the requester.
    always_comb begin
        if (busy)           rsp_code = RSP_WAIT;
        else if (!req_valid) rsp_code = RSP_NONE;
        else if (hit)       rsp_code = RSP_DONE;
        else                rsp_code = RSP_WAIT;
    end

    // Line base address: victim tag for writeback, request tag for refill.
    assign mem_addr = {(mem_write ? cur_tag : a_tag), a_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/wbdm_cache_chk.sv
// Port-level checker for wbdm_cache, attached with bind below.
module wbdm_cache_chk #(
    parameter int REQ_W  = 16,
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [REQ_W-1:0]  req_addr,
    input logic [1:0]        rsp_code,
    input logic              mem_req,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    assert_wait_in_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> rsp_code == 2'd1);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !mem_req) |-> rsp_code == 2'd0);

    assert_done_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_code == 2'd2 |-> !mem_req);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));

    assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_write) |=> (mem_req && !mem_write));

    assert_fill_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_write) |->
            (mem_addr[ADDR_W-1:OFF_W] == req_addr[ADDR_W-1:OFF_W]
             && mem_addr[OFF_W-1:0] == '0));
endmodule

bind wbdm_cache wbdm_cache_chk #(.REQ_W(REQ_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_code(rsp_code), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/wbdm_cache_bench.sv
// Bench: fixed 3-cycle line memory, reference word image and slot model.
module wbdm_cache_bench;
    localparam int LAT = 3;
    localparam int MEMW = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0] rsp_code;
    logic [31:0] rsp_rdata;
    logic mem_req, mem_write, mem_ack;
    logic [9:0] mem_addr;
    logic [127:0] mem_wdata, mem_rdata;

    int total = 0, bad = 0;
    logic [31:0] bmem [MEMW];   // backing store
    logic [31:0] rmem [MEMW];   // requester view
    logic [2:0] mtag [32];
    logic mval [32];
    logic mdirty [32];
    int wr_ev = 0, rd_ev = 0, last_wb = 0, last_rd = 0, wb_bad = 0;
    int cnt = 0;

    always #5 clk = ~clk;

    wbdm_cache u_wbdm_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_code(rsp_code),
        .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Fixed-latency line memory.
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0; mem_ack <= 1'b0; mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; cnt <= 0;
        end else if (mem_req) begin
            if (cnt == LAT - 1) begin
                mem_ack <= 1'b1;
                if (mem_write) begin
                    for (int k = 0; k < 4; k++) begin
                        bmem[int'(mem_addr) + k] <= mem_wdata[k*32 +: 32];
                        if (mem_wdata[k*32 +: 32] != rmem[int'(mem_addr) + k]) wb_bad = wb_bad + 1;
                    end
                    wr_ev = wr_ev + 1; last_wb = int'(mem_addr);
                end else begin
                    for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] <= bmem[int'(mem_addr) + k];
                    rd_ev = rd_ev + 1; last_rd = int'(mem_addr);
                end
            end else cnt <= cnt + 1;
        end
    end

    function automatic int wrap(int a);
        return ((a % MEMW) + MEMW) % MEMW;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One access; predicts waits, traffic and data from the slot model.
    task automatic access(bit wr, int a_raw, logic [31:0] wd);
        int a, idx, tg, waits, exp_waits, w0, r0, wb0, guard;
        bit miss, dirty;
        string rq;
        a = wrap(a_raw); idx = (a >> 2) & 31; tg = a >> 7;
        miss = !(mval[idx] && mtag[idx] == 3'(tg));
        dirty = miss && mdirty[idx];
        exp_waits = !miss ? 0 : (dirty ? 9 : 5);
        rq = !miss ? (wr ? "R4" : "R3") : (dirty ? "R7" : "R6");
        w0 = wr_ev; r0 = rd_ev; wb0 = wb_bad;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a_raw[15:0]; req_wdata = wd;
        waits = 0; guard = 0;
        forever begin
            @(negedge clk);
            if (rsp_code == 2'd2 || guard > 40) break;
            if (rsp_code == 2'd1) waits++;
            guard++;
        end
        chk(waits == exp_waits, rq, "wait cycles (R8)", waits, exp_waits);
        if (!wr) chk(rsp_rdata == rmem[a], rq, "read data", int'(rsp_rdata), int'(rmem[a]));
        chk(wr_ev - w0 == (dirty ? 1 : 0), rq, "writebacks", wr_ev - w0, dirty ? 1 : 0);
        chk(rd_ev - r0 == (miss ? 1 : 0), rq, "line reads", rd_ev - r0, miss ? 1 : 0);
        if (dirty) begin
            chk(last_wb == ((int'(mtag[idx]) << 7) | (idx << 2)), "R7", "writeback addr",
                last_wb, (int'(mtag[idx]) << 7) | (idx << 2));
            chk(wb_bad == wb0, "R7", "writeback data mismatches", wb_bad - wb0, 0);
        end
        if (miss) chk(last_rd == (a & ~3), "R6", "refill addr", last_rd, a & ~3);
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        if (miss) begin mval[idx] = 1'b1; mtag[idx] = 3'(tg); mdirty[idx] = 1'b0; end
        if (wr) begin rmem[a] = wd; mdirty[idx] = 1'b1; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w0;
        void'($urandom(32'd7));
        for (int i = 0; i < MEMW; i++) begin
            bmem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h1234;
            rmem[i] = bmem[i];
        end
        for (int i = 0; i < 32; i++) begin mval[i] = 1'b0; mtag[i] = '0; mdirty[i] = 1'b0; end
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_code == 2'd0, "R5", "idle rsp_code", int'(rsp_code), 0);
        chk(mem_req == 1'b0, "R5", "idle mem_req", int'(mem_req), 0);
        // R5/R2: first access to the example address is a clean miss.
        access(0, 'b0100111011, 0);
        access(0, 'b0100111000, 0);          // same line, R2 offset split -> hit
        access(1, 'b0100111001, 32'hA5A5_0001); // R4 write hit
        access(0, 'b0100111001, 0);          // R4 read back
        access(0, 'b0100111011 ^ (1 << 7), 0); // R2 tag differs -> R7 dirty miss
        // R10: clean refilled line, evict again: no writeback expected.
        w0 = wr_ev;
        access(0, 'b0100111011, 0);
        chk(wr_ev == w0, "R10", "writeback after clean refill", wr_ev - w0, 0);
        // R1: wrap negative and beyond-top addresses.
        access(1, -10, 32'hDEAD_0010);
        access(0, 1014, 0);
        access(0, MEMW + 25, 0);
        access(0, 25, 0);
        access(0, -(MEMW + 10), 0);
        // Random mix over a small slot pool for frequent evictions.
        for (int n = 0; n < 300; n++) begin
            int ra;
            ra = int'(($urandom % 8) << 7) | int'(($urandom % 4) << 2) | int'($urandom % 4);
            access($urandom % 3 == 0, ra, $urandom);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule